// File: doc/BRIEF.md
# SDRAM Burst Column Address Generator

This block produces the column addresses for one SDRAM read or write burst. A length code is written into a small burst-setting register. When a column command is issued, the block latches the 8-bit start column. From the next clock it presents one column per cycle, stepping through the burst in sequential order.

Bursts of 2, 4 and 8 wrap inside their naturally aligned block of columns. A full-page burst steps through all 256 columns modulo 256 and keeps going until a terminate command stops it. A new column command may arrive on any clock; it abandons the current burst and starts again from the new column. The final beat of a fixed-length burst is flagged. If the command asked for auto precharge, a precharge request is raised on that same beat.

Top module: `sdram_burst_colgen`

## Requirements
- R1: While reset is held, and on the first cycle after it, `valid_o`, `last_o` and `pre_req_o` are low. The stored length code resets to 000.
- R2: When `cmd_i` is high at a clock edge, `valid_o` is high after that edge and `col_o` equals the `start_col_i` sampled at that edge.
- R3: Length codes 001, 010 and 011 give bursts of 2, 4 and 8 beats. Each beat adds one to the low 1, 2 or 3 bits of the column, wrapping within the aligned block, while the upper bits stay fixed.
- R4: Length code 000, and the unused codes 100, 101 and 110, give a single-beat burst.
- R5: Length code 111 gives a full-page burst. The column advances by one modulo 256 every cycle, `last_o` never rises, and the burst runs until it is terminated or replaced.
- R6: `last_o` is high exactly on the final beat of a fixed-length burst. With no new command, `valid_o` is low on the following cycle.
- R7: `term_i` high at an edge without `cmd_i` makes `valid_o` low after that edge, and no `last_o` is produced. If `cmd_i` and `term_i` are high together, the command wins.
- R8: A command that arrives during a burst restarts the burst from its own start column, with a fresh beat count.
- R9: A write to the length code (`mode_we_i`) affects only bursts started by later commands. A command issued on the same edge as the write uses the previously stored code.
- R10: `pre_req_o` is high on exactly those cycles where `last_o` is high and `auto_pre_i` was high with the command that started the burst.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| mode_we_i | input | 1 | Write strobe for the burst length code |
| mode_bl_i | input | 3 | Burst length code |
| cmd_i | input | 1 | Column (read/write) command strobe |
| start_col_i | input | 8 | Start column captured with the command |
| auto_pre_i | input | 1 | Auto precharge requested with the command |
| term_i | input | 1 | Burst terminate command |
| col_o | output | 8 | Current burst column |
| valid_o | output | 1 | A burst beat is being presented |
| last_o | output | 1 | Final beat of a fixed-length burst |
| pre_req_o | output | 1 | Auto precharge request on the final beat |

## Verification
A wrong beat counter or a wrong latched length shows at the ports within at most eight cycles of the command. It appears as `last_o` on the wrong beat, or as `valid_o` staying high or dropping early. A wrong wrap mask corrupts `col_o` at the first block boundary: two cycles into a burst of 2, or at column 255 in a full page. A command or terminate that is not given priority, or a length write applied to a running burst, changes `valid_o` or `col_o` on the very next cycle. The bench compares all four outputs with a behavioural model on every clock, so each of these faults surfaces within that window.

// File: rtl/sdram_colgen_pkg.sv
package sdram_colgen_pkg;
  localparam logic [2:0] BL_CODE_1    = 3'b000;
  localparam logic [2:0] BL_CODE_2    = 3'b001;
  localparam logic [2:0] BL_CODE_4    = 3'b010;
  localparam logic [2:0] BL_CODE_8    = 3'b011;
  localparam logic [2:0] BL_CODE_PAGE = 3'b111;

  typedef struct packed {
    logic       full;  // full-page burst
    logic [1:0] lg;    // log2 of fixed burst length
  } bl_cfg_t;

  function automatic bl_cfg_t bl_decode(logic [2:0] code);
    bl_cfg_t c;
    c.full = 1'b0;
    c.lg   = 2'd0;
    case (code)
      BL_CODE_2:    c.lg = 2'd1;
      BL_CODE_4:    c.lg = 2'd2;
      BL_CODE_8:    c.lg = 2'd3;
      BL_CODE_PAGE: c.full = 1'b1;
      default:      c.lg = 2'd0;
    endcase
    return c;
  endfunction
endpackage

// File: rtl/colgen_mode_reg.sv
module colgen_mode_reg
  import sdram_colgen_pkg::*;
(
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          we_i,
  input  logic [2:0]    code_i,
  output bl_cfg_t       cfg_o
);
  logic [2:0] code_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   code_q <= BL_CODE_1;
    else if (we_i) code_q <= code_i;
  end

  assign cfg_o = bl_decode(code_q);

  // R9
  code_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !we_i |=> code_q == $past(code_q));
endmodule

// File: rtl/colgen_addr_step.sv
module colgen_addr_step #(
  parameter int COL_W = 8
) (
  input  logic [COL_W-1:0] col_i,
  input  logic [1:0]       lg_i,
  input  logic             full_i,
  output logic [COL_W-1:0] col_nxt_o
);
  logic [COL_W-1:0] mask;
  logic [COL_W-1:0] inc;

  // wrap mask: low lg bits, or all bits for full page
  for (genvar g = 0; g < COL_W; g++) begin : g_mask
    assign mask[g] = full_i | (g < int'(lg_i));
  end

  assign inc       = col_i + 1'b1;
  assign col_nxt_o = (col_i & ~mask) | (inc & mask);
endmodule

// File: rtl/colgen_burst_ctl.sv
module colgen_burst_ctl
  import sdram_colgen_pkg::*;
#(
  parameter int COL_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  bl_cfg_t          cfg_i,
  input  logic             cmd_i,
  input  logic [COL_W-1:0] start_col_i,
  input  logic             auto_pre_i,
  input  logic             term_i,
  output logic [COL_W-1:0] col_o,
  output logic             valid_o,
  output logic             last_o,
  output logic             pre_req_o
);
  localparam int CNT_W = 3;  // up to 8 counted beats

  logic             valid_q, full_q, ap_q;
  logic [1:0]       lg_q;
  logic [COL_W-1:0] col_q, col_nxt;
  logic [CNT_W-1:0] cnt_q, cnt_fin;

  colgen_addr_step #(.COL_W(COL_W)) u_step (
    .col_i    (col_q),
    .lg_i     (lg_q),
    .full_i   (full_q),
    .col_nxt_o(col_nxt)
  );

  for (genvar g = 0; g < CNT_W; g++) begin : g_fin
    assign cnt_fin[g] = (g < int'(lg_q));
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_q <= 1'b0;
      full_q  <= 1'b0;
      ap_q    <= 1'b0;
      lg_q    <= '0;
      col_q   <= '0;
      cnt_q   <= '0;
    end else if (cmd_i) begin
      valid_q <= 1'b1;
      full_q  <= cfg_i.full;
      lg_q    <= cfg_i.lg;
      ap_q    <= auto_pre_i;
      col_q   <= start_col_i;
      cnt_q   <= '0;
    end else if (term_i || last_o) begin
      valid_q <= 1'b0;
    end else if (valid_q) begin
      col_q <= col_nxt;
      cnt_q <= cnt_q + 1'b1;
    end
  end

  assign col_o     = col_q;
  assign valid_o   = valid_q;
  assign last_o    = valid_q & ~full_q & (cnt_q == cnt_fin);
  assign pre_req_o = last_o & ap_q;

  // R2
  start_col_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cmd_i |=> valid_o && col_o == $past(start_col_i));
  // R6
  last_valid_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    last_o |-> valid_o);
  // R6
  end_drop_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    last_o && !cmd_i |=> !valid_o);
  // R7
  term_drop_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    term_i && !cmd_i |=> !valid_o);
  // R3
  burst_cont_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o && !last_o && !term_i && !cmd_i |=> valid_o && col_o != $past(col_o));
  // R10
  pre_req_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pre_req_o |-> last_o);
endmodule

// File: rtl/sdram_burst_colgen.sv
module sdram_burst_colgen
  import sdram_colgen_pkg::*;
#(
  parameter int COL_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             mode_we_i,
  input  logic [2:0]       mode_bl_i,
  input  logic             cmd_i,
  input  logic [COL_W-1:0] start_col_i,
  input  logic             auto_pre_i,
  input  logic             term_i,
  output logic [COL_W-1:0] col_o,
  output logic             valid_o,
  output logic             last_o,
  output logic             pre_req_o
);
  bl_cfg_t cfg;

  colgen_mode_reg u_mode (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .we_i  (mode_we_i),
    .code_i(mode_bl_i),
    .cfg_o (cfg)
  );

  colgen_burst_ctl #(.COL_W(COL_W)) u_ctl (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .cfg_i      (cfg),
    .cmd_i      (cmd_i),
    .start_col_i(start_col_i),
    .auto_pre_i (auto_pre_i),
    .term_i     (term_i),
    .col_o      (col_o),
    .valid_o    (valid_o),
    .last_o     (last_o),
    .pre_req_o  (pre_req_o)
  );
endmodule

// File: tb/sdram_burst_colgen_test.sv
`timescale 1ns/1ps
module sdram_burst_colgen_test;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       mode_we = 1'b0, cmd = 1'b0, ap = 1'b0, term = 1'b0;
  logic [2:0] mode_bl = 3'd0;
  logic [7:0] scol = 8'd0;
  logic [7:0] col;
  logic       valid, last, pre_req;

  int tests = 0, fails = 0;

  // reference state
  bit m_act = 0, m_ap = 0;
  int m_col = 0, m_beat = 0, m_len = 1, m_code = 0;

  always #2.5 clk = ~clk;

  sdram_burst_colgen uut (
    .clk_i(clk), .rst_ni(rst_n), .mode_we_i(mode_we), .mode_bl_i(mode_bl),
    .cmd_i(cmd), .start_col_i(scol), .auto_pre_i(ap), .term_i(term),
    .col_o(col), .valid_o(valid), .last_o(last), .pre_req_o(pre_req)
  );

  function automatic int len_of(int code);
    case (code)
      1: return 2;
      2: return 4;
      3: return 8;
      7: return 0;  // full page
      default: return 1;
    endcase
  endfunction

  function automatic bit m_last();
    return m_act && m_len != 0 && m_beat == m_len - 1;
  endfunction

  task automatic compare(string tag);
    bit e_last = m_last();
    bit e_pre  = e_last && m_ap;
    tests++;
    if (valid !== m_act || last !== e_last || pre_req !== e_pre ||
        (m_act && col !== m_col[7:0])) begin
      fails++;
      $display("FAIL %s: got v=%0b l=%0b p=%0b col=%02h exp v=%0b l=%0b p=%0b col=%02h",
               tag, valid, last, pre_req, col, m_act, e_last, e_pre, m_col[7:0]);
    end
  endtask

  task automatic cyc(bit c, int sc, bit t, bit we, int bl, bit a, string tag);
    bit lst;
    cmd = c; scol = sc[7:0]; term = t; mode_we = we; mode_bl = bl[2:0]; ap = a;
    @(posedge clk);
    lst = m_last();
    if (c) begin
      m_act = 1; m_col = sc & 255; m_beat = 0; m_len = len_of(m_code); m_ap = a;
    end else if (t || lst) begin
      m_act = 0;
    end else if (m_act) begin
      if (m_len == 0) m_col = (m_col + 1) % 256;
      else m_col = (m_col - m_col % m_len) + ((m_col + 1) % m_len);
      m_beat++;
    end
    if (we) m_code = bl & 7;
    @(negedge clk);
    compare(tag);
  endtask

  task automatic idle(int n, string tag);
    for (int i = 0; i < n; i++) cyc(0, 0, 0, 0, 0, 0, tag);
  endtask

  task automatic setmode(int bl, string tag);
    cyc(0, 0, 0, 1, bl, 0, tag);
  endtask

  initial begin
    #(200000 * 5);
    fails++;
    $display("FAIL watchdog: got hung run exp completion");
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    compare("R1");
    rst_n = 1'b1;
    idle(2, "R1");

    // R3 burst of 8 wrapping inside aligned block
    setmode(3, "R9");
    cyc(1, 8'h35, 0, 0, 0, 0, "R2");
    idle(9, "R3");
    // R3 burst of 2
    setmode(1, "R9");
    cyc(1, 8'h0F, 0, 0, 0, 0, "R2");
    idle(3, "R3");
    // R3 burst of 4 at top of range
    setmode(2, "R9");
    cyc(1, 8'hFE, 0, 0, 0, 0, "R2");
    idle(5, "R3");
    // R4 single beat, defined and unused codes
    setmode(0, "R9");
    cyc(1, 8'h80, 0, 0, 0, 0, "R4");
    idle(2, "R4");
    for (int k = 4; k < 7; k++) begin
      setmode(k, "R9");
      cyc(1, 8'h10 + k, 0, 0, 0, 0, "R4");
      idle(2, "R4");
    end
    // R5 full page across 255->0, then terminate
    setmode(7, "R9");
    cyc(1, 8'hFD, 0, 0, 0, 1, "R5");
    idle(300, "R5");
    cyc(0, 0, 1, 0, 0, 0, "R7");
    idle(2, "R7");
    // R7 terminate mid burst, and terminate with command
    setmode(3, "R9");
    cyc(1, 8'h20, 0, 0, 0, 1, "R7");
    idle(2, "R7");
    cyc(0, 0, 1, 0, 0, 0, "R7");
    idle(2, "R7");
    cyc(1, 8'h44, 0, 0, 0, 0, "R7");
    cyc(1, 8'h52, 1, 0, 0, 0, "R7");
    idle(9, "R7");
    // R8 interrupting commands
    cyc(1, 8'h10, 0, 0, 0, 0, "R8");
    idle(2, "R8");
    cyc(1, 8'h42, 0, 0, 0, 1, "R8");
    cyc(1, 8'h47, 0, 0, 0, 0, "R8");
    idle(9, "R8");
    // R6 last with a new command on the last beat
    cyc(1, 8'h60, 0, 0, 0, 0, "R6");
    idle(7, "R6");
    cyc(1, 8'h68, 0, 0, 0, 0, "R6");
    idle(9, "R6");
    // R9 length write during a burst, and with a command
    setmode(2, "R9");
    cyc(1, 8'h31, 0, 0, 0, 0, "R9");
    cyc(0, 0, 0, 1, 3, 0, "R9");
    idle(4, "R9");
    cyc(1, 8'h70, 0, 1, 0, 0, "R9");
    idle(5, "R9");
    cyc(1, 8'h71, 0, 0, 0, 0, "R9");
    idle(3, "R9");
    // R10 precharge request on the last beat
    setmode(1, "R9");
    cyc(1, 8'h05, 0, 0, 0, 1, "R10");
    idle(3, "R10");
    cyc(1, 8'h06, 0, 0, 0, 0, "R10");
    idle(3, "R10");
    // R8 mixed random traffic
    for (int i = 0; i < 600; i++) begin
      int r = int'($urandom % 100);
      cyc(r < 15, int'($urandom % 256), r >= 15 && r < 20,
          r >= 20 && r < 26, int'($urandom % 8), r % 2 == 0, "R8");
    end
    idle(10, "R8");

    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule